// File: doc/BRIEF.md
# Pixel Configuration Latch Loader

This block serves one double-column of a pixel matrix. It holds a configuration word for every pixel of the column and a serial chain with one stage per pixel. Software-side logic shifts a bit-plane into the chain serially, then opens the latches of the whole double-column for one clock while a strobe vector names which bit positions of every pixel take the chain's contents. Other bit positions keep their values.

Read-back runs the other way. In read mode, opening the column copies into the chain, for every pixel, the OR of the latch bits named by the strobe. The chain is then shifted out serially. The latches have no reset or clear path. Only a load or a read-back can touch them, and a read-back never changes them. The configuration words drive static outputs, one field per pixel.

Top module: `pcl_dcol_loader`

## Requirements
- R1: When `rst_n` is low at a rising edge, the serial chain is cleared, so `ser_out` is 0 on the first cycle after reset is released.
- R2: At a rising edge with `shift_en` high and no read capture, stage 0 takes `ser_in` and stage k takes stage k-1. `ser_out` is the last stage (pixel ROWS-1). After ROWS shifts, the bit shifted in first sits in pixel ROWS-1.
- R3: In load mode (`rd_mode`=0) with `xfer` high at a rising edge, every pixel r and every bit p with `strobe[p]`=1 takes the chain stage r as it was before that edge. The bit is visible at `cfg_o[r*NBITS+p]`.
- R4: A load changes no bit whose strobe is 0. With `xfer` low, no configuration bit changes, whatever the shift or strobe inputs do.
- R5: In read mode (`rd_mode`=1) with `xfer` high at a rising edge, chain stage r takes the OR of the bits of pixel r whose strobe is 1. An all-zero strobe captures 0.
- R6: When a read capture and `shift_en` fall in the same cycle, the capture wins and no shift takes place.
- R7: When a load and a shift fall in the same cycle, the latches take the chain contents from before the shift, and the chain still shifts.
- R8: A read capture leaves every configuration bit unchanged.
- R9: Reset does not alter any configuration bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift and latch clock |
| rst_n | input | 1 | Synchronous active-low reset of the serial chain only |
| ser_in | input | 1 | Serial data into chain stage 0 |
| shift_en | input | 1 | Shift the chain by one stage at the rising edge |
| ser_out | output | 1 | Last chain stage |
| rd_mode | input | 1 | 0 = load latches from the chain, 1 = read latches into the chain |
| xfer | input | 1 | Opens the column latches (load) or requests a capture (read) |
| strobe | input | NBITS | Selects the bit positions that take part |
| cfg_o | output | ROWS*NBITS | Configuration word of pixel r at bits r*NBITS +: NBITS |

## Verification
Two functions can fall in one cycle: a column transfer and a chain shift. The bench provokes both orderings. It raises `shift_en` together with a load, and it raises `shift_en` together with a read capture. For the load, it compares `cfg_o` with the pre-shift chain image and drains the chain to see that the shift still took place. For the read, it drains the chain and expects the unshifted capture.

// File: rtl/pcl_pkg.sv
// Shared types for the pixel configuration latch loader.
package pcl_pkg;
    // Column transfer direction selected by the rd_mode pin.
    typedef enum logic {
        PCL_LOAD = 1'b0,
        PCL_READ = 1'b1
    } pcl_mode_e;
endpackage

// File: rtl/pcl_mode_ctrl.sv
// Decodes mode and transfer request into the latch-open and capture enables.
// Assumes rd_mode and xfer are stable around the rising edge.
module pcl_mode_ctrl
    import pcl_pkg::*;
(
    input  logic rd_mode,
    input  logic xfer,
    output logic load_open,
    output logic capture_en
);
    pcl_mode_e mode;

    // Map the pin onto the mode type and derive the two enables.
    always_comb begin
        mode       = pcl_mode_e'(rd_mode);
        load_open  = xfer && (mode == PCL_LOAD);
        capture_en = xfer && (mode == PCL_READ);
    end
endmodule

// File: rtl/pcl_shift_chain.sv
// One-bit-per-pixel serial chain with a parallel capture port.
// Capture has priority over shifting. Assumes ROWS >= 2.
module pcl_shift_chain #(
    parameter int ROWS = 336
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            capture_en,
    input  logic            ser_in,
    input  logic [ROWS-1:0] cap_vec,
    output logic [ROWS-1:0] chain_q,
    output logic            ser_out
);
    // Reset clears the chain, capture overrides shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (capture_en) begin
            chain_q <= cap_vec;
        end else if (shift_en) begin
            chain_q <= {chain_q[ROWS-2:0], ser_in};
        end
    end

    // The last stage feeds the serial output.
    assign ser_out = chain_q[ROWS-1];
endmodule

// File: rtl/pcl_pixel_cell.sv
// Configuration word of one pixel: NBITS latch bits, each written from the
// pixel's chain stage when the column is open and its strobe is set.
// The latches are modelled as enabled storage with no reset path.
module pcl_pixel_cell #(
    parameter int NBITS = 13
) (
    input  logic             clk,
    input  logic             load_open,
    input  logic [NBITS-1:0] strobe,
    input  logic             d,
    output logic [NBITS-1:0] q,
    output logic             rd_bit
);
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        // Each bit follows the chain stage only while its strobe is set.
        always_ff @(posedge clk) begin
            if (load_open && strobe[b]) begin
                q[b] <= d;
            end
        end
    end

    // Read-back value is the OR of the strobed bits.
    assign rd_bit = |(q & strobe);
endmodule

// File: rtl/pcl_dcol_loader.sv
// Double-column configuration loader: a serial chain with one stage per
// pixel, a per-pixel configuration word, and strobe-selected load and
// read-back across the whole column. Configuration bits never reset.
module pcl_dcol_loader #(
    parameter int ROWS  = 336,
    parameter int NBITS = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_in,
    input  logic                  shift_en,
    output logic                  ser_out,
    input  logic                  rd_mode,
    input  logic                  xfer,
    input  logic [NBITS-1:0]      strobe,
    output logic [ROWS*NBITS-1:0] cfg_o
);
    localparam int CFG_W = ROWS * NBITS;

    logic            load_open;
    logic            capture_en;
    logic [ROWS-1:0] chain_q;
    logic [ROWS-1:0] rd_vec;

    pcl_mode_ctrl u_ctrl (
        .rd_mode    (rd_mode),
        .xfer       (xfer),
        .load_open  (load_open),
        .capture_en (capture_en)
    );

    pcl_shift_chain #(.ROWS(ROWS)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .ser_in     (ser_in),
        .cap_vec    (rd_vec),
        .chain_q    (chain_q),
        .ser_out    (ser_out)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_pix
        pcl_pixel_cell #(.NBITS(NBITS)) u_cell (
            .clk       (clk),
            .load_open (load_open),
            .strobe    (strobe),
            .d         (chain_q[r]),
            .q         (cfg_o[r*NBITS +: NBITS]),
            .rd_bit    (rd_vec[r])
        );
    end

    // Elaboration-time guard on the parameters.
    initial begin
        if (ROWS < 2 || NBITS < 1 || CFG_W < 2) begin
            $error("pcl_dcol_loader: ROWS must be >= 2 and NBITS >= 1");
        end
    end
endmodule

// File: rtl/pcl_dcol_checker.sv
// Protocol checker for pcl_dcol_loader. It is bound to the top module.
module pcl_dcol_checker #(
    parameter int ROWS  = 336,
    parameter int NBITS = 13
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ser_in,
    input logic                  shift_en,
    input logic                  ser_out,
    input logic                  rd_mode,
    input logic                  xfer,
    input logic [NBITS-1:0]      strobe,
    input logic [ROWS-1:0]       chain_q,
    input logic [ROWS*NBITS-1:0] cfg_o
);
    localparam int TOP = (ROWS - 1) * NBITS + NBITS - 1;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ser_out == 1'b0)); // R1
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !(rd_mode && xfer)) |=> (chain_q[0] == $past(ser_in))); // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !(rd_mode && xfer)) |=> (ser_out == $past(chain_q[ROWS-2]))); // R2
    AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !rd_mode && strobe[0]) |=> (cfg_o[0] == $past(chain_q[0]))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(cfg_o)); // R4
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && rd_mode && strobe == '0) |=> (chain_q == '0)); // R5
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && rd_mode && shift_en && strobe == '0) |=> (ser_out == 1'b0)); // R6
    AST_LOAD_PRE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !rd_mode && shift_en && strobe[NBITS-1]) |=> (cfg_o[TOP] == $past(chain_q[ROWS-1]))); // R7
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && rd_mode) |=> $stable(cfg_o)); // R8
endmodule

bind pcl_dcol_loader pcl_dcol_checker #(.ROWS(ROWS), .NBITS(NBITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_in   (ser_in),
    .shift_en (shift_en),
    .ser_out  (ser_out),
    .rd_mode  (rd_mode),
    .xfer     (xfer),
    .strobe   (strobe),
    .chain_q  (chain_q),
    .cfg_o    (cfg_o)
);

// File: tb/sim_pcl_dcol_loader.sv
// Directed bench for pcl_dcol_loader: one task per scenario.
module sim_pcl_dcol_loader;
    localparam int ROWS  = 336;
    localparam int NBITS = 13;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  ser_in = 1'b0;
    logic                  shift_en = 1'b0;
    logic                  ser_out;
    logic                  rd_mode = 1'b0;
    logic                  xfer = 1'b0;
    logic [NBITS-1:0]      strobe = '0;
    logic [ROWS*NBITS-1:0] cfg_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [NBITS-1:0] m_cfg [ROWS];
    logic [ROWS-1:0]  m_sr;

    always #10 clk = ~clk;

    pcl_dcol_loader #(.ROWS(ROWS), .NBITS(NBITS)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
        .ser_out(ser_out), .rd_mode(rd_mode), .xfer(xfer),
        .strobe(strobe), .cfg_o(cfg_o)
    );

    function automatic logic pat(int p, int r);
        return ((r * (2 * p + 3) + 5 * p) % 11) < 5;
    endfunction

    // One clock with the given inputs. The model is updated from the requirements.
    task automatic cyc(input logic si, input logic sh, input logic md,
                       input logic xf, input logic [NBITS-1:0] stb);
        logic [ROWS-1:0] old_sr;
        ser_in = si; shift_en = sh; rd_mode = md; xfer = xf; strobe = stb;
        @(posedge clk);
        old_sr = m_sr;
        if (md && xf) begin
            for (int r = 0; r < ROWS; r++) m_sr[r] = |(m_cfg[r] & stb);
        end else if (sh) begin
            m_sr = {m_sr[ROWS-2:0], si};
        end
        if (!md && xf) begin
            for (int r = 0; r < ROWS; r++)
                for (int p = 0; p < NBITS; p++)
                    if (stb[p]) m_cfg[r][p] = old_sr[r];
        end
        @(negedge clk);
        shift_en = 1'b0; xfer = 1'b0;
    endtask

    task automatic check_cfg(input string tag);
        int bad = 0;
        int first = -1;
        for (int r = 0; r < ROWS; r++)
            if (cfg_o[r*NBITS +: NBITS] !== m_cfg[r]) begin
                bad++;
                if (first < 0) first = r;
            end
        n_chk++;
        if (bad != 0) begin
            n_bad++;
            $display("FAIL %s: pixel %0d actual=%h expected=%h (%0d pixels differ)",
                     tag, first, cfg_o[first*NBITS +: NBITS], m_cfg[first], bad);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Shift the whole chain out and compare each serial bit.
    task automatic drain(input string tag);
        int bad = 0;
        logic a = 1'b0;
        logic e = 1'b0;
        for (int i = 0; i < ROWS; i++) begin
            if (ser_out !== m_sr[ROWS-1]) begin
                if (bad == 0) begin a = ser_out; e = m_sr[ROWS-1]; end
                bad++;
            end
            cyc(1'b0, 1'b1, 1'b0, 1'b0, '0);
        end
        n_chk++;
        if (bad != 0) begin
            n_bad++;
            $display("FAIL %s: first serial bit actual=%b expected=%b (%0d differ)", tag, a, e, bad);
        end
    endtask

    task automatic fill(input int p);
        for (int i = 0; i < ROWS; i++) cyc(pat(p, ROWS - 1 - i), 1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        m_sr = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset();
        check_bit("R1 serial out after reset", ser_out, 1'b0);
    endtask

    task automatic t_load_all;
        for (int p = 0; p < NBITS; p++) begin
            fill(p);
            cyc(1'b0, 1'b0, 1'b0, 1'b1, NBITS'(1) << p);
        end
        check_cfg("R3 load of every plane");
        check_bit("R2 first-shifted bit lands in last pixel", cfg_o[(ROWS-1)*NBITS], pat(0, ROWS-1));
    endtask

    task automatic t_readback;
        for (int p = 0; p < NBITS; p++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b1, NBITS'(1) << p);
            drain("R5 R2 single plane read-back");
        end
        check_cfg("R8 reads leave latches unchanged");
    endtask

    task automatic t_partial;
        fill(NBITS + 4);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 13'h0024);
        check_cfg("R4 only strobed planes 2 and 5 written");
        fill(NBITS + 7);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, '1);
        check_cfg("R4 strobe without transfer writes nothing");
    endtask

    task automatic t_or;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 13'h1003);
        drain("R5 OR of planes 0 1 12");
        fill(3);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, '0);
        check_bit("R5 empty strobe captures zero", ser_out, 1'b0);
        drain("R5 empty strobe chain");
    endtask

    task automatic t_collide;
        fill(6);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 13'h0008);
        check_bit("R6 capture beats shift, last stage", ser_out, m_cfg[ROWS-1][3]);
        drain("R6 capture beats shift");
        fill(8);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 13'h1001);
        check_cfg("R7 load takes pre-shift chain");
        drain("R7 chain shifted during load");
    endtask

    task automatic t_reset_keeps;
        fill(2);
        do_reset();
        check_cfg("R9 reset leaves latches");
        check_bit("R1 chain cleared by reset", ser_out, 1'b0);
        drain("R1 whole chain cleared");
    endtask

    initial begin
        m_sr = '0;
        for (int r = 0; r < ROWS; r++) m_cfg[r] = '0;
        @(negedge clk);
        t_reset();
        t_load_all();
        t_readback();
        t_partial();
        t_or();
        t_collide();
        t_reset_keeps();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule